// File: doc/BRIEF.md
# Presence-Detect EEPROM Target on an I2C Bus

This block is a 256-byte presence-detect memory with a two-wire serial (I2C) target front end. A host controller reads module description bytes from it and may store its own data in the upper half. The lower 128 bytes hold factory data and the upper 128 are free for the user. The array comes out of reset with a parameter image: a short head of factory bytes, zeros elsewhere, and a checksum byte at index 63. That byte equals the low 8 bits of the sum of bytes 0 through 62.

The 7-bit bus address is the fixed prefix 1010 followed by three strap inputs that the board ties high or low. The block drives SDA only as an open-drain pull-down, through an output enable. It samples SCL and SDA on its own clock through a short synchronizer. Byte writes, current-address reads, random reads (a dummy write followed by a repeated start) and sequential reads are supported. A single word pointer advances after every byte moved and wraps from 255 to 0. A write-protect input blocks every array update, but the target keeps acknowledging the bus.

Top module: `spd_target`

## Requirements
- R1: After reset sdaOe is 0, the pointer is 0, and the array holds the image: byte i for i < 16 is HEAD[8*i+7:8*i], bytes 16 to 62 and 64 to 255 are 0.
- R2: The target acknowledges an address byte whose upper seven bits (MSB first) equal {4'b1010, strap[2:0]}, with strap[0] as the lowest address bit. Any other address gets no acknowledge, and SDA stays released until the next START.
- R3: In a write transfer (bit 0 of the address byte = 0), the word address byte and each data byte are acknowledged. Each data byte is stored at the pointer, and then the pointer advances.
- R4: While wpIn is high when a data byte completes, the array keeps its contents, and the address, word and data bytes are still acknowledged.
- R5: A word address byte loads the pointer, so a repeated START with a read address (bit 0 = 1) returns the byte at that word address.
- R6: A read transfer with no preceding word address returns the byte at the pointer that the previous transfer left behind.
- R7: In a read, every controller acknowledge (SDA low in the ninth bit) makes the target send the next byte, from the next address. Bytes are sent MSB first.
- R8: The pointer wraps from 255 to 0, for both reads and writes.
- R9: Byte 63 of the reset image is the low 8 bits of the sum of bytes 0 to 62.
- R10: A controller NACK ends the read. SDA stays released through the NACK bit and afterwards, and a STOP returns the target to idle, ready for the next START.
- R11: The target changes sdaOe only while SCL is low. SDA does not change while SCL is high in data or acknowledge bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, which oversamples the bus lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| strap | input | 3 | Board straps, the low three bits of the bus address |
| wpIn | input | 1 | Write protect, active high |
| sdaOe | output | 1 | Pull SDA low when 1, release it when 0 |

## Verification
An array update and a pointer wrap can happen in the same clock cycle. When a data byte completes with the pointer at 255, the byte is committed to address 255 and the pointer rolls to 0 on the same edge. The bench provokes this with a write transfer that starts at word address 255 and carries two data bytes. It then reads back from 255 sequentially. It passes only if the first byte landed at 255, the second at 0, and the read stream itself crosses the wrap in the right order.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RX_DEV,
    ST_RX_WORD,
    ST_RX_DATA,
    ST_ACK_DEV,
    ST_ACK_WORD,
    ST_ACK_DATA,
    ST_TX,
    ST_TX_ACK
  } spdState_t;

  // strobes from control to datapath, one clock wide
  typedef struct packed {
    logic rxShift;  // shift sampled SDA into the receive byte
    logic ptrLoad;  // take receive byte as word pointer
    logic memWr;    // commit receive byte at pointer
    logic ptrInc;   // advance pointer by one
    logic txLoad;   // fetch byte at pointer into transmit register
    logic txShift;  // move transmit register to the next bit
  } spdStrobe_t;

endpackage

// File: rtl/spd_ctrl.sv
module spd_ctrl
  import spd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       devMatch,
  input  logic       rwBit,
  input  logic       txBit,
  output logic       sdaBit,
  output spdStrobe_t stb,
  output logic       sdaOe
);

  localparam int CNT_W = 4;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startEv, stopEv;

  spdState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;
  logic ackSeen, ackSeenNxt;

  // synchronizer chains, idle bus is high
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sdaBit  = sdaS;

  always_comb begin
    stateNxt   = state;
    bitCntNxt  = bitCnt;
    ackSeenNxt = ackSeen;
    stb        = '0;
    if (stopEv) begin
      stateNxt = ST_IDLE;
    end else if (startEv) begin
      stateNxt  = ST_RX_DEV;
      bitCntNxt = '0;
    end else begin
      unique case (state)
        ST_RX_DEV, ST_RX_WORD, ST_RX_DATA: begin
          if (sclRise) begin
            stb.rxShift = 1'b1;
            bitCntNxt   = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == CNT_W'(8)) begin
            bitCntNxt = '0;
            if (state == ST_RX_DEV) begin
              stateNxt = devMatch ? ST_ACK_DEV : ST_IDLE;
            end else if (state == ST_RX_WORD) begin
              stateNxt    = ST_ACK_WORD;
              stb.ptrLoad = 1'b1;
            end else begin
              stateNxt   = ST_ACK_DATA;
              stb.memWr  = 1'b1;
              stb.ptrInc = 1'b1;
            end
          end
        end
        ST_ACK_DEV: begin
          if (sclFall) begin
            if (rwBit) begin
              stateNxt   = ST_TX;
              stb.txLoad = 1'b1;
              stb.ptrInc = 1'b1;
            end else begin
              stateNxt = ST_RX_WORD;
            end
          end
        end
        ST_ACK_WORD, ST_ACK_DATA: begin
          if (sclFall) stateNxt = ST_RX_DATA;
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == CNT_W'(7)) begin
              stateNxt  = ST_TX_ACK;
              bitCntNxt = '0;
            end else begin
              stb.txShift = 1'b1;
              bitCntNxt   = bitCnt + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclRise) ackSeenNxt = ~sdaS;
          if (sclFall) begin
            if (ackSeen) begin
              stateNxt   = ST_TX;
              stb.txLoad = 1'b1;
              stb.ptrInc = 1'b1;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      ackSeen <= 1'b0;
    end else begin
      state   <= stateNxt;
      bitCnt  <= bitCntNxt;
      ackSeen <= ackSeenNxt;
    end
  end

  // open drain: only ever pull low
  assign sdaOe = (state == ST_ACK_DEV) || (state == ST_ACK_WORD) ||
                 (state == ST_ACK_DATA) || ((state == ST_TX) && !txBit);

endmodule

// File: rtl/spd_datapath.sv
module spd_datapath
  import spd_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int HEAD_LEN = 16,
  parameter logic [8*HEAD_LEN-1:0] HEAD = '0,
  parameter int SUM_IDX  = 63,
  parameter int STRAP_W  = 3,
  parameter logic [6-STRAP_W:0] DEV_PREFIX = '0,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  spdStrobe_t             stb,
  input  logic                   sdaBit,
  input  logic                   wpIn,
  input  logic [STRAP_W-1:0]     strap,
  output logic                   devMatch,
  output logic                   rwBit,
  output logic                   txBit,
  output logic [7:0]             rxByte,
  output logic [PTR_W-1:0]       ptrQ,
  output logic [DEPTH-1:0][7:0]  memImage
);

  logic [DEPTH-1:0][7:0] memArr;
  logic [7:0] txReg;

  function automatic logic [7:0] headByte(input int idx);
    if (idx < HEAD_LEN) return HEAD[8*idx +: 8];
    return 8'h00;
  endfunction

  function automatic logic [7:0] imageByte(input int idx);
    logic [7:0] acc;
    if (idx == SUM_IDX) begin
      acc = 8'h00;
      for (int j = 0; j < SUM_IDX; j++) acc = acc + headByte(j);
      return acc;
    end
    return headByte(idx);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= imageByte(i);
    end else if (stb.memWr && !wpIn) begin
      memArr[ptrQ] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      ptrQ   <= '0;
      txReg  <= 8'hFF;
    end else begin
      if (stb.rxShift) rxByte <= {rxByte[6:0], sdaBit};
      if (stb.ptrLoad)     ptrQ <= rxByte[PTR_W-1:0];
      else if (stb.ptrInc) ptrQ <= ptrQ + 1'b1;
      if (stb.txLoad)       txReg <= memArr[ptrQ];
      else if (stb.txShift) txReg <= {txReg[6:0], 1'b1};
    end
  end

  assign devMatch = (rxByte[7:1] == {DEV_PREFIX, strap});
  assign rwBit    = rxByte[0];
  assign txBit    = txReg[7];
  assign memImage = memArr;

endmodule

// File: rtl/spd_target.sv
module spd_target
  import spd_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int HEAD_LEN = 16,
  parameter logic [8*HEAD_LEN-1:0] HEAD =
    128'h01_00_08_80_00_54_75_01_00_40_01_0A_0C_04_08_80,
  parameter int SUM_IDX  = 63,
  parameter int STRAP_W  = 3,
  parameter logic [6-STRAP_W:0] DEV_PREFIX = 4'b1010,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wpIn,
  output logic               sdaOe
);

  spdStrobe_t ctlStb;
  logic devMatch, rwBit, txBit, sdaBit;
  logic [7:0] rxByte;
  logic [PTR_W-1:0] ptrQ;
  logic [DEPTH-1:0][7:0] memImage;

  spd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .devMatch(devMatch), .rwBit(rwBit), .txBit(txBit),
    .sdaBit(sdaBit), .stb(ctlStb), .sdaOe(sdaOe)
  );

  spd_datapath #(
    .DEPTH(DEPTH), .HEAD_LEN(HEAD_LEN), .HEAD(HEAD), .SUM_IDX(SUM_IDX),
    .STRAP_W(STRAP_W), .DEV_PREFIX(DEV_PREFIX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .sdaBit(sdaBit), .wpIn(wpIn),
    .strap(strap), .devMatch(devMatch), .rwBit(rwBit), .txBit(txBit),
    .rxByte(rxByte), .ptrQ(ptrQ), .memImage(memImage)
  );

endmodule

// File: rtl/spd_target_checker.sv
module spd_target_checker
  import spd_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int SUM_IDX = 63,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaOe,
  input logic                  wpIn,
  input spdStrobe_t            stb,
  input logic [PTR_W-1:0]      ptrQ,
  input logic [7:0]            rxByte,
  input logic [DEPTH-1:0][7:0] memImage
);

  function automatic logic [7:0] lowSum(input logic [DEPTH-1:0][7:0] img);
    logic [7:0] acc;
    acc = 8'h00;
    for (int j = 0; j < SUM_IDX; j++) acc = acc + img[j];
    return acc;
  endfunction

  // R9: the reset image carries its own checksum
  always @(posedge clk) begin
    if (!rstN) begin
      assert_checksum_R9: assert (memImage[SUM_IDX] == lowSum(memImage))
        else $error("checksum byte does not match image");
    end
  end

  assert_wp_freeze_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(wpIn) |-> memImage == $past(memImage));

  assert_write_store_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.memWr && !wpIn) |-> memImage[$past(ptrQ)] == $past(rxByte));

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.ptrInc) && !$past(stb.ptrLoad) |-> ptrQ == PTR_W'($past(ptrQ) + 1'b1));

  assert_word_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.ptrLoad) |-> ptrQ == $past(rxByte[PTR_W-1:0]));

  assert_sda_steady_R11: assert property (@(posedge clk) disable iff (!rstN)
    sclIn && $past(sclIn) && $past(sclIn, 2) && $past(sclIn, 3) |-> $stable(sdaOe));

endmodule

bind spd_target spd_target_checker #(.DEPTH(DEPTH), .SUM_IDX(SUM_IDX)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .wpIn(wpIn),
  .stb(ctlStb), .ptrQ(ptrQ), .rxByte(rxByte), .memImage(memImage)
);

// File: tb/tb_spd_target.sv
module tb_spd_target;

  localparam int Q = 10;  // quarter bus period in clocks
  localparam logic [127:0] HEAD =
    128'h01_00_08_80_00_54_75_01_00_40_01_0A_0C_04_08_80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic [2:0] strapV = 3'b101;
  logic wpV = 1'b0;
  logic sdaOe;
  logic sdaLine;

  int vectors = 0;
  int miscompares = 0;
  int stableErr = 0;
  logic ackBitHigh;
  logic [7:0] rd [0:3];

  always #2 clk = ~clk;

  assign sdaLine = sdaDrv & ~sdaOe;

  spd_target dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .strap(strapV), .wpIn(wpV), .sdaOe(sdaOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitQ();
      sclDrv = 1'b1; waitQ(); waitQ();
      sclDrv = 1'b0;
    end
    waitQ();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    acked = ~sdaLine; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic recvByte(output logic [7:0] b, input logic ackIt);
    logic s0;
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      sclDrv = 1'b1; waitQ();
      s0 = sdaLine; b[i] = sdaLine; waitQ();
      if (sdaLine !== s0) stableErr++;
      sclDrv = 1'b0;
    end
    waitQ();
    sdaDrv = ~ackIt; waitQ();
    sclDrv = 1'b1; waitQ();
    ackBitHigh = (sdaOe == 1'b0); waitQ();
    sclDrv = 1'b0; waitQ();
    sdaDrv = 1'b1;
  endtask

  function automatic logic [7:0] devByte(input logic rw);
    return {4'b1010, strapV, rw};
  endfunction

  function automatic logic [7:0] imageAt(input int idx);
    logic [7:0] acc;
    if (idx < 16) return HEAD[8*idx +: 8];
    if (idx == 63) begin
      acc = 8'h00;
      for (int j = 0; j < 16; j++) acc = acc + HEAD[8*j +: 8];
      return acc;
    end
    return 8'h00;
  endfunction

  // write n (1..3) bytes from word address wa, acks ANDed
  task automatic writeSeq(input logic [7:0] wa, input logic [7:0] d0, d1, d2,
                          input int n, output logic allAck);
    logic a;
    allAck = 1'b1;
    busStart();
    sendByte(devByte(1'b0), a); allAck &= a;
    sendByte(wa, a); allAck &= a;
    sendByte(d0, a); allAck &= a;
    if (n > 1) begin sendByte(d1, a); allAck &= a; end
    if (n > 2) begin sendByte(d2, a); allAck &= a; end
    busStop();
  endtask

  task automatic readRandom(input logic [7:0] wa, input int n);
    logic a;
    busStart();
    sendByte(devByte(1'b0), a);
    sendByte(wa, a);
    busStart();
    sendByte(devByte(1'b1), a);
    for (int k = 0; k < n; k++) recvByte(rd[k], k != n - 1);
    busStop();
  endtask

  task automatic readCurrent(input int n);
    logic a;
    busStart();
    sendByte(devByte(1'b1), a);
    for (int k = 0; k < n; k++) recvByte(rd[k], k != n - 1);
    busStop();
  endtask

  task automatic t_reset();
    chk("R1 sdaOe after reset", sdaOe, 1'b0);
    readCurrent(1);
    chk("R1 pointer at 0 after reset", rd[0], imageAt(0));
  endtask

  task automatic t_address();
    logic a;
    busStart();
    sendByte(devByte(1'b0), a);
    chk("R2 matching address acked", a, 1'b1);
    busStop();
    busStart();
    sendByte({4'b1010, 3'b011, 1'b0}, a);
    chk("R2 foreign address not acked", a, 1'b0);
    sendByte(8'h00, a);
    chk("R2 no ack after foreign address", a, 1'b0);
    busStop();
  endtask

  task automatic t_randomRead();
    readRandom(8'h00, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R5 R7 sequential factory bytes", rd[k], imageAt(k));
    end
    readRandom(8'd20, 1);
    chk("R1 zero filled factory byte", rd[0], 8'h00);
  endtask

  task automatic t_checksum();
    readRandom(8'd62, 2);
    chk("R9 byte before checksum", rd[0], 8'h00);
    chk("R9 checksum byte", rd[1], imageAt(63));
  endtask

  task automatic t_write();
    logic a;
    writeSeq(8'd140, 8'h11, 8'h22, 8'h33, 3, a);
    chk("R3 write bytes acked", a, 1'b1);
    readRandom(8'd140, 3);
    chk("R3 byte 140", rd[0], 8'h11);
    chk("R3 byte 141", rd[1], 8'h22);
    chk("R3 byte 142", rd[2], 8'h33);
    readRandom(8'd140, 1);
    readCurrent(1);
    chk("R6 current address read", rd[0], 8'h22);
  endtask

  task automatic t_protect();
    logic a;
    wpV = 1'b1;
    writeSeq(8'd140, 8'hEE, 8'hDD, 8'h00, 2, a);
    chk("R4 acked while protected", a, 1'b1);
    wpV = 1'b0;
    readRandom(8'd140, 2);
    chk("R4 byte 140 kept", rd[0], 8'h11);
    chk("R4 byte 141 kept", rd[1], 8'h22);
  endtask

  task automatic t_wrap();
    logic a;
    writeSeq(8'd255, 8'h77, 8'h99, 8'h00, 2, a);
    chk("R8 wrap write acked", a, 1'b1);
    readRandom(8'd255, 3);
    chk("R8 byte 255", rd[0], 8'h77);
    chk("R8 byte 0 after wrap", rd[1], 8'h99);
    chk("R8 byte 1 after wrap", rd[2], imageAt(1));
  endtask

  task automatic t_nack();
    logic a;
    readRandom(8'd4, 1);
    chk("R10 read before nack", rd[0], imageAt(4));
    chk("R10 released in nack bit", ackBitHigh, 1'b1);
    chk("R10 released after stop", sdaOe, 1'b0);
    busStart();
    sendByte(devByte(1'b1), a);
    chk("R10 next transfer acked", a, 1'b1);
    recvByte(rd[0], 1'b0);
    busStop();
    chk("R10 R6 pointer continued", rd[0], imageAt(5));
  endtask

  task automatic t_strap();
    logic a;
    logic [2:0] oldStrap;
    oldStrap = strapV;
    strapV = 3'b010;
    busStart();
    sendByte({4'b1010, oldStrap, 1'b0}, a);
    chk("R2 old strap address ignored", a, 1'b0);
    busStop();
    busStart();
    sendByte(devByte(1'b0), a);
    chk("R2 new strap address acked", a, 1'b1);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired, all requirements");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_address();
    t_randomRead();
    t_checksum();
    t_write();
    t_protect();
    t_wrap();
    t_nack();
    t_strap();
    chk("R11 data steady while SCL high", stableErr, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule